// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressable Data Memory

This block is a 32-bit data memory in which every byte has its own address and four consecutive bytes form a word. Word addresses are multiples of four, so word number n lives at byte address 4n. One port serves both whole-word accesses and single-byte accesses, and a size select chooses between them. Writes happen on the rising clock edge. Reads are combinational from the address.

A mode input picks how the four bytes inside a word are numbered. In big-endian mode, the byte at the lowest address is the most significant byte of the word. In little-endian mode, the byte at the lowest address is the least significant byte. A word access returns the same 32-bit value in either mode. Only the lane that a byte access reaches depends on the mode.

A word access to an address that is not a multiple of four raises a misalignment flag and is suppressed. The memory depth is a parameter. Address bits above the implemented range are ignored, so the address space wraps onto the physical words.

Top module: `mem_endian`

## Requirements
- R1: A word write with `we`=1, `is_byte`=0 and `addr[1:0]`=0 stores all 32 bits of `wdata` at the rising clock edge. A later word read of that address returns the same value on `rdata` combinationally.
- R2: A word read returns the same 32-bit value whichever value `big_end` has, both at write time and at read time.
- R3: With `big_end`=1, a byte access at word offset `addr[1:0]`=k uses word bits [31-8k:24-8k]. Offset 0 is the most significant byte.
- R4: With `big_end`=0, a byte access at word offset `addr[1:0]`=k uses word bits [8k+7:8k]. Offset 0 is the least significant byte.
- R5: A byte read places the selected byte on `rdata[7:0]` and drives `rdata[31:8]` to zero.
- R6: A byte write takes `wdata[7:0]` and changes only the one selected byte lane. The other three bytes of the word keep their values.
- R7: A word access with `addr[1:0]`≠0 sets `misalign`, writes nothing and reads zero. For aligned word accesses and for all byte accesses, `misalign` is 0.
- R8: Address bits at and above bit log2(DEPTH)+2 are ignored. Addresses that differ only in those bits reach the same storage.
- R9: A synchronous active-high `rst` clears every byte to zero and takes priority over a write in the same cycle.
- R10: With `we`=0, no storage changes, whatever `wdata` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes on rising edge |
| rst | input | 1 | Synchronous active-high reset, clears contents |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data (byte writes use bits [7:0]) |
| we | input | 1 | Write enable |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| big_end | input | 1 | 1 = big-endian byte numbering, 0 = little-endian |
| rdata | output | 32 | Combinational read data |
| misalign | output | 1 | Word access with nonzero low address bits |

## Verification
The test word 0x11223344 has four distinct bytes. Reading it back byte by byte at offsets 0 to 3 in each mode shows whether the lane order is reversed, mirrored correctly or stuck on one lane. The same word is read as a whole in the opposite mode, which separates a correct design from one that swaps bytes on word accesses. Byte writes into the middle lanes in both modes check that neighbouring lanes are preserved and that each mode reaches its own lane. Misaligned word writes, writes to high-aliased addresses, cycles with `we` low, and a reset asserted together with a write check the suppression, wrap-around and priority rules.

// File: rtl/mem_endian_pkg.sv
package mem_endian_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned OFS_W   = $clog2(LANES);

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;

    typedef struct packed {
        logic              is_byte;
        logic              write;
        byte_order_e       order;
        logic [OFS_W-1:0]  ofs;
    } access_t;

    // Physical lane (0 = bits [7:0]) reached by a byte offset in a given order.
    function automatic logic [OFS_W-1:0] lane_of(input logic [OFS_W-1:0] ofs,
                                                 input byte_order_e order);
        logic [OFS_W-1:0] top_lane;
        top_lane = OFS_W'(LANES - 1);
        return (order == ORDER_BIG) ? (top_lane - ofs) : ofs;
    endfunction

endpackage

// File: rtl/mem_lane_ctl.sv
module mem_lane_ctl
    import mem_endian_pkg::*;
(
    input  access_t                    acc,
    input  logic [WORD_W-1:0]          wdata,
    output logic                       bad_align,
    output logic [OFS_W-1:0]           lane,
    output logic [LANES-1:0]           lane_we,
    output logic [WORD_W-1:0]          lane_wdata
);

    always_comb begin
        bad_align = !acc.is_byte && (acc.ofs != '0);
        lane      = lane_of(acc.ofs, acc.order);
        lane_we   = '0;
        if (acc.write && !bad_align) begin
            if (acc.is_byte) lane_we[lane] = 1'b1;
            else             lane_we       = '1;
        end
        lane_wdata = acc.is_byte ? {LANES{wdata[7:0]}} : wdata;
    end

endmodule

// File: rtl/mem_lane_store.sv
module mem_lane_store
    import mem_endian_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     idx,
    input  logic [LANES-1:0]     lane_we,
    input  logic [WORD_W-1:0]    lane_wdata,
    output logic [WORD_W-1:0]    rword
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= 8'h00;
            end else if (lane_we[g]) begin
                bank[idx] <= lane_wdata[g*8 +: 8];
            end
        end

        assign rword[g*8 +: 8] = bank[idx];
    end

endmodule

// File: rtl/mem_read_fmt.sv
module mem_read_fmt
    import mem_endian_pkg::*;
(
    input  logic [WORD_W-1:0]  rword,
    input  logic               is_byte,
    input  logic               bad_align,
    input  logic [OFS_W-1:0]   lane,
    output logic [WORD_W-1:0]  rdata
);

    always_comb begin
        if (bad_align)    rdata = '0;
        else if (is_byte) rdata = {{(WORD_W-8){1'b0}}, rword[lane*8 +: 8]};
        else              rdata = rword;
    end

endmodule

// File: rtl/mem_endian.sv
module mem_endian
    import mem_endian_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [31:0]  addr,
    input  logic [31:0]  wdata,
    input  logic         we,
    input  logic         is_byte,
    input  logic         big_end,
    output logic [31:0]  rdata,
    output logic         misalign
);

    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned HI_LO = IDX_W + OFS_W;

    access_t            acc;
    logic [IDX_W-1:0]   idx;
    logic [OFS_W-1:0]   lane;
    logic [LANES-1:0]   lane_we;
    logic [WORD_W-1:0]  lane_wdata;
    logic [WORD_W-1:0]  rword;
    logic               unused_hi_addr;

    assign acc.is_byte = is_byte;
    assign acc.write   = we;
    assign acc.order   = big_end ? ORDER_BIG : ORDER_LITTLE;
    assign acc.ofs     = addr[OFS_W-1:0];
    assign idx         = addr[HI_LO-1:OFS_W];
    assign unused_hi_addr = ^addr[31:HI_LO];

    mem_lane_ctl u_ctl (
        .acc        (acc),
        .wdata      (wdata),
        .bad_align  (misalign),
        .lane       (lane),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata)
    );

    mem_lane_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .idx        (idx),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata),
        .rword      (rword)
    );

    mem_read_fmt u_fmt (
        .rword      (rword),
        .is_byte    (is_byte),
        .bad_align  (misalign),
        .lane       (lane),
        .rdata      (rdata)
    );

endmodule

// File: rtl/mem_endian_chk.sv
module mem_endian_chk (
    input logic         clk,
    input logic         rst,
    input logic [31:0]  addr,
    input logic [31:0]  wdata,
    input logic         we,
    input logic         is_byte,
    input logic [31:0]  rdata,
    input logic         misalign,
    input logic [3:0]   lane_we
);

    p_word_all_lanes_r1: assert property (@(posedge clk) disable iff (rst)
        (we && !is_byte && addr[1:0] == 2'b00) |-> lane_we == 4'hF);

    p_word_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_byte && addr[1:0] == 2'b00 && !$past(rst) &&
         $past(we && !is_byte && addr[1:0] == 2'b00) && addr == $past(addr))
        |-> rdata == $past(wdata));

    p_zero_ext_r5: assert property (@(posedge clk) disable iff (rst)
        is_byte |-> rdata[31:8] == 24'h0);

    p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (rst)
        (we && is_byte) |-> $countones(lane_we) == 1);

    p_misalign_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (lane_we == 4'h0 && rdata == 32'h0));

    p_byte_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        is_byte |-> !misalign);

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rdata == 32'h0);

    p_idle_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        !we |-> lane_we == 4'h0);

endmodule

bind mem_endian mem_endian_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wdata    (wdata),
    .we       (we),
    .is_byte  (is_byte),
    .rdata    (rdata),
    .misalign (misalign),
    .lane_we  (lane_we)
);

// File: tb/mem_endian_bench.sv
module mem_endian_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        is_byte = 1'b0;
    logic        big_end = 1'b0;
    logic [31:0] rdata;
    logic        misalign;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_endian #(.DEPTH(DEPTH)) u_mem_endian (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
        .is_byte(is_byte), .big_end(big_end), .rdata(rdata), .misalign(misalign)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d,
                      input logic bsel, input logic be);
        @(negedge clk);
        addr = a; wdata = d; is_byte = bsel; big_end = be; we = 1'b1;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic bsel, input logic be,
                      output logic [31:0] v, output logic f);
        @(negedge clk);
        we = 1'b0; addr = a; is_byte = bsel; big_end = be;
        #1 v = rdata; f = misalign;
    endtask

    task automatic t_reset_state();
        logic [31:0] v; logic f;
        rd(32'h0, 1'b0, 1'b0, v, f);
        check("R9 reset word 0", v, 32'h0);
        check("R7 aligned flag low", {31'h0, f}, 32'h0);
        rd(32'h3FC, 1'b0, 1'b1, v, f);
        check("R9 reset last word", v, 32'h0);
    endtask

    task automatic t_word_rw();
        logic [31:0] v; logic f;
        wr(32'h20, 32'h11223344, 1'b0, 1'b0);
        rd(32'h20, 1'b0, 1'b0, v, f);
        check("R1 word readback", v, 32'h11223344);
        rd(32'h20, 1'b0, 1'b1, v, f);
        check("R2 word same in big mode", v, 32'h11223344);
        wr(32'h24, 32'hCAFEF00D, 1'b0, 1'b1);
        rd(32'h24, 1'b0, 1'b0, v, f);
        check("R2 big write little read", v, 32'hCAFEF00D);
    endtask

    task automatic t_byte_order();
        logic [31:0] v; logic f;
        logic [7:0] be_exp [4];
        be_exp = '{8'h11, 8'h22, 8'h33, 8'h44};
        for (int k = 0; k < 4; k++) begin
            rd(32'h20 + k, 1'b1, 1'b1, v, f);
            check("R3 big byte read", v, {24'h0, be_exp[k]});
            check("R5 byte zero ext / R7 flag", {v[31:8], 7'h0, f}, 32'h0);
            rd(32'h20 + k, 1'b1, 1'b0, v, f);
            check("R4 little byte read", v, {24'h0, be_exp[3-k]});
        end
    endtask

    task automatic t_byte_write();
        logic [31:0] v; logic f;
        wr(32'h21, 32'hFFFFFFAA, 1'b1, 1'b1);
        rd(32'h20, 1'b0, 1'b0, v, f);
        check("R6 big byte write lane", v, 32'h11AA3344);
        wr(32'h21, 32'h000000BB, 1'b1, 1'b0);
        rd(32'h20, 1'b0, 1'b0, v, f);
        check("R6 little byte write lane", v, 32'h11AABB44);
        wr(32'h27, 32'h00000077, 1'b1, 1'b0);
        rd(32'h24, 1'b0, 1'b1, v, f);
        check("R4 little offset 3 is msb", v, 32'h77FEF00D);
    endtask

    task automatic t_misalign();
        logic [31:0] v; logic f;
        wr(32'h42, 32'hDEADBEEF, 1'b0, 1'b0);
        rd(32'h42, 1'b0, 1'b0, v, f);
        check("R7 misaligned flag", {31'h0, f}, 32'h1);
        check("R7 misaligned read zero", v, 32'h0);
        rd(32'h40, 1'b0, 1'b0, v, f);
        check("R7 misaligned no write", v, 32'h0);
        rd(32'h43, 1'b1, 1'b1, v, f);
        check("R7 byte access never misaligned", {31'h0, f}, 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] v; logic f;
        wr(32'h30 + DEPTH*4, 32'h5A5A1234, 1'b0, 1'b0);
        rd(32'h30, 1'b0, 1'b0, v, f);
        check("R8 high bits ignored write", v, 32'h5A5A1234);
        rd(32'hFFFF0030, 1'b0, 1'b1, v, f);
        check("R8 high bits ignored read", v, 32'h5A5A1234);
    endtask

    task automatic t_no_we();
        logic [31:0] v; logic f;
        @(negedge clk);
        we = 1'b0; addr = 32'h20; is_byte = 1'b0; wdata = 32'h0BADF00D;
        @(posedge clk);
        rd(32'h20, 1'b0, 1'b0, v, f);
        check("R10 no write when we low", v, 32'h11AABB44);
    endtask

    task automatic t_reset_priority();
        logic [31:0] v; logic f;
        @(negedge clk);
        rst = 1'b1; we = 1'b1; addr = 32'h50; wdata = 32'h99999999; is_byte = 1'b0;
        @(posedge clk);
        #1 rst = 1'b0; we = 1'b0;
        rd(32'h50, 1'b0, 1'b0, v, f);
        check("R9 reset beats write", v, 32'h0);
        rd(32'h20, 1'b0, 1'b0, v, f);
        check("R9 reset clears contents", v, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset_state();
        t_word_rw();
        t_byte_order();
        t_byte_write();
        t_misalign();
        t_alias();
        t_no_we();
        t_reset_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule